// File: doc/BRIEF.md
# Three-Stage Cascadable Watchdog Timer

This block is a watchdog built from three counters that run from a slow tick (`lfTick`, a one-cycle enable in the system clock domain). The first two counters are 16 bits wide. Each compares its count with a programmable target. When the count equals the target on an increment, a hit occurs. The hit can raise an interrupt, request a system reset, or do both in two stages. The third counter is 32 bits wide and only counts. It flags an interrupt every time a chosen bit of its count flips, which gives a power-of-two period.

Each of the second and third counters can count either slow ticks or carry events from the counter before it. Chaining them this way gives timeouts far longer than 16 bits. Software sets the block up through a small write-only register port. It keeps the watchdog alive by pulsing a per-counter service strobe, which zeroes that counter. It acknowledges interrupts by writing ones to the sticky flags.

Top module: `tri_stage_wdog`

## Requirements
- R1: After reset all three counts, all flags, `irqOut` and `rstReq` are 0. All configuration fields are 0.
- R2: A counter increments by one on each edge where its increment source is active and its `cntEn` bit is 1. While its `cntEn` bit is 0 it holds its value, produces no hit and passes no carry to the next counter.
- R3: Counters 0 and 1 hit on an increment that starts from a count equal to the target. With clear-on-match off, the counter keeps counting and wraps from all-ones to 0.
- R4: With clear-on-match on, the increment that hits loads 0 instead of target+1. A target of 0 is then treated as 1.
- R5: With its chain bit set, counter 1 counts carries from counter 0, and counter 2 counts carries from counter 1. A carry is the hit when clear-on-match is on, and otherwise the wrap from all-ones to 0.
- R6: Counter 2 hits on each increment that changes count bit `togSel` (0..31), so with tick every cycle it hits every 2^togSel ticks.
- R7: The mode field of counters 0 and 1 is encoded as 0 = off, 1 = interrupt, 2 = reset, 3 = interrupt then reset. A hit sets the counter's sticky flag when the mode is non-zero. For counter 2, the flag is set when its interrupt-enable bit is set. `irqOut` is the OR of the flags whose counter has mode 1 or 3, or has the counter 2 interrupt enabled.
- R8: Writing `irqClrWe` with a 1 in bit i of `irqClrMask` clears flag i on that edge. A hit on the same edge wins, and the flag stays set.
- R9: In mode 2, `rstReq` is 1 for the one cycle after the edge that hit.
- R10: In mode 3, a hit raises `rstReq` only if the flag was already set and is not being cleared on that edge. Otherwise it only sets the flag.
- R11: A service strobe on `svcStrobe[i]` zeroes counter i on that edge and suppresses any hit or carry of that counter on that edge.
- R12: The register map is as follows. Address 0 holds target 0 in bits [15:0], and address 1 holds target 1 in bits [15:0]. Address 2 holds: mode0 [1:0], mode1 [3:2], counter 2 interrupt enable [4], clear-on-match 0 [5], clear-on-match 1 [6], chain 0→1 [7], chain 1→2 [8], togSel [13:9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| lfTick | input | 1 | Slow tick enable |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 2 | Configuration register address |
| cfgWdata | input | 32 | Configuration write data |
| cntEn | input | 3 | Per-counter run enable |
| svcStrobe | input | 3 | Per-counter service (zero) strobe |
| irqClrWe | input | 1 | Flag clear strobe |
| irqClrMask | input | 3 | Write-1-to-clear mask for the flags |
| irqFlags | output | 3 | Sticky hit flags |
| irqOut | output | 1 | Combined interrupt |
| rstReq | output | 1 | Reset request pulse |
| count0 | output | 16 | Counter 0 value |
| count1 | output | 16 | Counter 1 value |
| count2 | output | 32 | Counter 2 value |

## Verification
Every count, flag and reset request is registered. Each therefore reflects the inputs seen at one rising edge, and is visible just after that edge. `irqOut` is a gate on registered flags and configuration, so it follows in the same cycle as the flag. The bench drives stimulus one nanosecond after an edge and advances exactly one edge per step. It samples one nanosecond after that edge. Every expected value is thus tied to a counted number of edges, and ordering between processes cannot affect it. Long chains, such as the full 16-bit wrap that carries into counter 1, are walked tick by tick, and only the end state is checked.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
  localparam int CNT_W   = 16;
  localparam int BIG_W   = 32;
  localparam int SEL_W   = $clog2(BIG_W);
  localparam int NUM_CNT = 3;
  localparam int ADDR_W  = 2;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'd0,
    MODE_IRQ     = 2'd1,
    MODE_RST     = 2'd2,
    MODE_IRQ_RST = 2'd3
  } mode_e;

  typedef struct packed {
    logic [CNT_W-1:0] match0;
    logic [CNT_W-1:0] match1;
    mode_e            mode0;
    mode_e            mode1;
    logic             irq2En;
    logic             clr0;
    logic             clr1;
    logic             casc01;
    logic             casc12;
    logic [SEL_W-1:0] togSel;
  } cfg_t;

  typedef struct packed {
    logic               tick;
    logic [NUM_CNT-1:0] run;
    logic [NUM_CNT-1:0] svc;
  } strobe_t;

  typedef struct packed {
    logic [NUM_CNT-1:0] hit;
  } evt_t;
endpackage

// File: rtl/tsw_match_cnt.sv
module tsw_match_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inc,
  input  logic         svc,
  input  logic         clrOnMatch,
  input  logic [W-1:0] matchVal,
  output logic [W-1:0] count,
  output logic         hit,
  output logic         casc
);
  localparam logic [W-1:0] ONE = 1;

  logic [W-1:0] target;
  logic         stepNow;
  logic         atTarget;

  always_comb begin
    // a zero target is meaningless when the count restarts on a hit
    target   = (clrOnMatch && matchVal == '0) ? ONE : matchVal;
    stepNow  = inc & ~svc;
    atTarget = (count == target);
    hit      = stepNow & atTarget;
    casc     = clrOnMatch ? hit : (stepNow & (&count));
  end

  always_ff @(posedge clk) begin
    if (!rstN)        count <= '0;
    else if (svc)     count <= '0;
    else if (stepNow) count <= (clrOnMatch && atTarget) ? '0 : count + ONE;
  end
endmodule

// File: rtl/tsw_datapath.sv
module tsw_datapath
  import tsw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  output evt_t              evt,
  output logic [CNT_W-1:0]  count0,
  output logic [CNT_W-1:0]  count1,
  output logic [BIG_W-1:0]  count2
);
  localparam logic [BIG_W-1:0] ONE2 = 1;

  logic inc0, inc1, inc2;
  logic hit0, hit1, hit2;
  logic casc0, casc1, unusedCasc2;
  logic [BIG_W-1:0] nxt2, flip2;

  assign inc0 = stb.run[0] & stb.tick;

  tsw_match_cnt #(.W(CNT_W)) u_cnt0 (
    .clk(clk), .rstN(rstN), .inc(inc0), .svc(stb.svc[0]),
    .clrOnMatch(cfg.clr0), .matchVal(cfg.match0),
    .count(count0), .hit(hit0), .casc(casc0)
  );

  assign inc1 = stb.run[1] & (cfg.casc01 ? casc0 : stb.tick);

  tsw_match_cnt #(.W(CNT_W)) u_cnt1 (
    .clk(clk), .rstN(rstN), .inc(inc1), .svc(stb.svc[1]),
    .clrOnMatch(cfg.clr1), .matchVal(cfg.match1),
    .count(count1), .hit(hit1), .casc(casc1)
  );

  // free-running third stage: event when the selected bit flips
  always_comb begin
    inc2        = stb.run[2] & (cfg.casc12 ? casc1 : stb.tick) & ~stb.svc[2];
    nxt2        = count2 + ONE2;
    flip2       = count2 ^ nxt2;
    hit2        = inc2 & flip2[cfg.togSel];
    unusedCasc2 = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           count2 <= '0;
    else if (stb.svc[2]) count2 <= '0;
    else if (inc2)       count2 <= nxt2;
  end

  assign evt.hit = {hit2, hit1, hit0};
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
  import tsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lfTick,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic [NUM_CNT-1:0] cntEn,
  input  logic [NUM_CNT-1:0] svcStrobe,
  input  logic               irqClrWe,
  input  logic [NUM_CNT-1:0] irqClrMask,
  input  evt_t               evt,
  output cfg_t               cfg,
  output strobe_t            stb,
  output logic [NUM_CNT-1:0] irqFlags,
  output logic               irqOut,
  output logic               rstReq
);
  logic [NUM_CNT-1:0] clrNow, arm, irqEn;
  logic               rstNext;
  mode_e              modeOf [2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (cfgWe) begin
      unique case (cfgAddr)
        2'd0: cfg.match0 <= cfgWdata[CNT_W-1:0];
        2'd1: cfg.match1 <= cfgWdata[CNT_W-1:0];
        2'd2: begin
          cfg.mode0  <= mode_e'(cfgWdata[1:0]);
          cfg.mode1  <= mode_e'(cfgWdata[3:2]);
          cfg.irq2En <= cfgWdata[4];
          cfg.clr0   <= cfgWdata[5];
          cfg.clr1   <= cfgWdata[6];
          cfg.casc01 <= cfgWdata[7];
          cfg.casc12 <= cfgWdata[8];
          cfg.togSel <= cfgWdata[9 +: SEL_W];
        end
        default: ;
      endcase
    end
  end

  assign stb.tick = lfTick;
  assign stb.run  = cntEn;
  assign stb.svc  = svcStrobe;

  always_comb begin
    modeOf[0] = cfg.mode0;
    modeOf[1] = cfg.mode1;
    clrNow    = irqClrWe ? irqClrMask : '0;
    rstNext   = 1'b0;
    for (int i = 0; i < 2; i++) begin
      arm[i]   = (modeOf[i] != MODE_OFF);
      irqEn[i] = (modeOf[i] == MODE_IRQ) || (modeOf[i] == MODE_IRQ_RST);
      if (evt.hit[i]) begin
        if (modeOf[i] == MODE_RST) rstNext = 1'b1;
        if (modeOf[i] == MODE_IRQ_RST && irqFlags[i] && !clrNow[i]) rstNext = 1'b1;
      end
    end
    arm[2]   = cfg.irq2En;
    irqEn[2] = cfg.irq2En;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlags <= '0;
      rstReq   <= 1'b0;
    end else begin
      irqFlags <= (irqFlags & ~clrNow) | (evt.hit & arm);
      rstReq   <= rstNext;
    end
  end

  assign irqOut = |(irqFlags & irqEn);
endmodule

// File: rtl/tri_stage_wdog.sv
module tri_stage_wdog
  import tsw_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               lfTick,
  input  logic               cfgWe,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [DATA_W-1:0]  cfgWdata,
  input  logic [NUM_CNT-1:0] cntEn,
  input  logic [NUM_CNT-1:0] svcStrobe,
  input  logic               irqClrWe,
  input  logic [NUM_CNT-1:0] irqClrMask,
  output logic [NUM_CNT-1:0] irqFlags,
  output logic               irqOut,
  output logic               rstReq,
  output logic [CNT_W-1:0]   count0,
  output logic [CNT_W-1:0]   count1,
  output logic [BIG_W-1:0]   count2
);
  cfg_t    cfgBus;
  strobe_t stbBus;
  evt_t    evtBus;

  tsw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lfTick(lfTick),
    .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .cntEn(cntEn), .svcStrobe(svcStrobe),
    .irqClrWe(irqClrWe), .irqClrMask(irqClrMask),
    .evt(evtBus), .cfg(cfgBus), .stb(stbBus),
    .irqFlags(irqFlags), .irqOut(irqOut), .rstReq(rstReq)
  );

  tsw_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfg(cfgBus), .stb(stbBus), .evt(evtBus),
    .count0(count0), .count1(count1), .count2(count2)
  );
endmodule

// File: rtl/tsw_checker.sv
module tsw_checker
  import tsw_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic [NUM_CNT-1:0] cntEn,
  input logic [NUM_CNT-1:0] svcStrobe,
  input logic               irqClrWe,
  input logic [NUM_CNT-1:0] irqClrMask,
  input logic [NUM_CNT-1:0] irqFlags,
  input logic               irqOut,
  input logic               rstReq,
  input logic [CNT_W-1:0]   count0,
  input evt_t               evt,
  input cfg_t               cfg
);
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn[0] && !svcStrobe[0]) |=> $stable(count0));

  a_r11_service_zeroes: assert property (@(posedge clk) disable iff (!rstN)
    svcStrobe[0] |=> (count0 == '0));

  a_r7_hit_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (evt.hit[0] && cfg.mode0 != MODE_OFF) |=> irqFlags[0]);

  a_r8_w1c_clears: assert property (@(posedge clk) disable iff (!rstN)
    (irqClrWe && irqClrMask[0] && !evt.hit[0]) |=> !irqFlags[0]);

  a_r9_reset_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (evt.hit[0] && cfg.mode0 == MODE_RST) |=> rstReq);

  a_r7_quiet_when_clear: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlags == '0) |-> !irqOut);
endmodule

bind tri_stage_wdog tsw_checker u_chk (
  .clk(clk), .rstN(rstN), .cntEn(cntEn), .svcStrobe(svcStrobe),
  .irqClrWe(irqClrWe), .irqClrMask(irqClrMask), .irqFlags(irqFlags),
  .irqOut(irqOut), .rstReq(rstReq), .count0(count0),
  .evt(evtBus), .cfg(cfgBus)
);

// File: tb/tri_stage_wdog_tb.sv
`timescale 1ns/1ps
module tri_stage_wdog_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        lfTick = 0;
  logic        cfgWe = 0;
  logic [1:0]  cfgAddr = 0;
  logic [31:0] cfgWdata = 0;
  logic [2:0]  cntEn = 0;
  logic [2:0]  svcStrobe = 0;
  logic        irqClrWe = 0;
  logic [2:0]  irqClrMask = 0;
  logic [2:0]  irqFlags;
  logic        irqOut, rstReq;
  logic [15:0] count0, count1;
  logic [31:0] count2;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  tri_stage_wdog u_dut (
    .clk(clk), .rstN(rstN), .lfTick(lfTick), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cntEn(cntEn), .svcStrobe(svcStrobe),
    .irqClrWe(irqClrWe), .irqClrMask(irqClrMask), .irqFlags(irqFlags),
    .irqOut(irqOut), .rstReq(rstReq), .count0(count0), .count1(count1),
    .count2(count2)
  );

  typedef struct packed {
    logic        tick;
    logic        en;
    logic        svc;
    logic [15:0] cnt;
    logic        flg;
  } row_t;

  // counter 0, target 3, clear-on-match, interrupt mode (R2, R4, R11)
  localparam row_t ROWS [12] = '{
    '{1'b1, 1'b1, 1'b0, 16'd1, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd2, 1'b0},
    '{1'b0, 1'b1, 1'b0, 16'd2, 1'b0},
    '{1'b1, 1'b0, 1'b0, 16'd2, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd3, 1'b0},
    '{1'b1, 1'b1, 1'b0, 16'd0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd1, 1'b1},
    '{1'b1, 1'b1, 1'b1, 16'd0, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd1, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd2, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd3, 1'b1},
    '{1'b1, 1'b1, 1'b0, 16'd0, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic t);
    lfTick = t;
    @(posedge clk);
    #1;
    lfTick = 0; cfgWe = 0; svcStrobe = 0; irqClrWe = 0; irqClrMask = 0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) step(1'b1);
  endtask

  task automatic wcfg(input logic [1:0] a, input logic [31:0] d);
    cfgWe = 1; cfgAddr = a; cfgWdata = d;
    step(1'b0);
  endtask

  task automatic restart(input logic [2:0] svcMask);
    svcStrobe = svcMask; irqClrWe = 1; irqClrMask = 3'b111;
    step(1'b0);
  endtask

  // R12 control word layout
  function automatic logic [31:0] ctl(input logic [1:0] m0, input logic [1:0] m1,
      input logic i2, input logic c0, input logic c1, input logic k01,
      input logic k12, input logic [4:0] sel);
    return {18'd0, sel, k12, k01, c1, c0, i2, m1, m0};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count0", count0, 0);
    chk("R1 count2", count2, 0);
    chk("R1 flags", irqFlags, 0);
    chk("R1 irq/rst", {irqOut, rstReq}, 0);
    rstN = 1;

    // R12 writes, then table walk for R2 R4 R11
    wcfg(2'd0, 32'd3);
    wcfg(2'd2, ctl(2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0));
    for (int r = 0; r < 12; r++) begin
      cntEn = {2'b00, ROWS[r].en};
      svcStrobe[0] = ROWS[r].svc;
      step(ROWS[r].tick);
      chk($sformatf("R4 row %0d count0", r), count0, ROWS[r].cnt);
      chk($sformatf("R7 row %0d flag0", r), irqFlags[0], ROWS[r].flg);
      chk($sformatf("R7 row %0d irq", r), irqOut, ROWS[r].flg);
    end

    // R8 write-1-to-clear
    irqClrWe = 1; irqClrMask = 3'b001;
    step(1'b0);
    chk("R8 clear flag0", {irqFlags[0], irqOut}, 0);

    // R3 hit without clear; R5 wrap carries into counter 1
    wcfg(2'd0, 32'd2);
    wcfg(2'd2, ctl(2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0));
    cntEn = 3'b011;
    restart(3'b011);
    ticks(2);
    chk("R3 no hit yet", {count0, 15'd0, irqFlags[0]}, {16'd2, 16'd0});
    ticks(1);
    chk("R3 hit keeps counting", {count0, 15'd0, irqFlags[0]}, {16'd3, 16'd1});
    ticks(65533);
    chk("R3 wrap count0", count0, 0);
    chk("R5 wrap carry count1", count1, 1);

    // R5 carry is the hit under clear-on-match
    wcfg(2'd0, 32'd1);
    wcfg(2'd2, ctl(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 5'd0));
    restart(3'b011);
    ticks(4);
    chk("R5 chained count", {count0, count1}, {16'd0, 16'd2});
    // R2 disabled counter passes no carry
    cntEn = 3'b010;
    ticks(4);
    chk("R2 no carry when off", {count0, count1}, {16'd0, 16'd2});

    // R6 bit-flip events on counter 2, bit 2
    wcfg(2'd2, ctl(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 5'd2));
    cntEn = 3'b100;
    restart(3'b100);
    ticks(3);
    chk("R6 before flip", irqFlags[2], 0);
    ticks(1);
    chk("R6 first flip", {irqFlags[2], irqOut, count2[3:0]}, {1'b1, 1'b1, 4'd4});
    irqClrWe = 1; irqClrMask = 3'b100;
    step(1'b0);
    ticks(3);
    chk("R6 between flips", irqFlags[2], 0);
    ticks(1);
    chk("R6 second flip", {irqFlags[2], count2[3:0]}, {1'b1, 4'd8});

    // R9 reset-only mode
    wcfg(2'd0, 32'd2);
    wcfg(2'd2, ctl(2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0));
    cntEn = 3'b001;
    restart(3'b001);
    ticks(2);
    chk("R9 before hit", rstReq, 0);
    ticks(1);
    chk("R9 pulse", {rstReq, irqFlags[0], irqOut}, 3'b110);
    step(1'b0);
    chk("R9 one cycle", rstReq, 0);
    // R11 service prevents reset
    restart(3'b001);
    ticks(2);
    svcStrobe = 3'b001;
    step(1'b1);
    chk("R11 service blocks", {count0, 15'd0, rstReq}, 32'd0);

    // R10 interrupt then reset
    wcfg(2'd0, 32'd1);
    wcfg(2'd2, ctl(2'd3, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0));
    restart(3'b001);
    ticks(2);
    chk("R10 first hit", {irqFlags[0], irqOut, rstReq}, 3'b110);
    ticks(2);
    chk("R10 second hit", rstReq, 1);
    irqClrWe = 1; irqClrMask = 3'b001;
    step(1'b0);
    ticks(2);
    chk("R10 cleared before hit", {irqFlags[0], rstReq}, 2'b10);
    ticks(1);
    irqClrWe = 1; irqClrMask = 3'b001;
    step(1'b1);
    chk("R8 set wins over clear", {irqFlags[0], rstReq}, 2'b10);

    // R4 zero target treated as one
    wcfg(2'd0, 32'd0);
    wcfg(2'd2, ctl(2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0));
    restart(3'b001);
    ticks(1);
    chk("R4 zero target step1", {count0, 15'd0, irqFlags[0]}, {16'd1, 16'd0});
    ticks(1);
    chk("R4 zero target hit", {count0, 15'd0, irqFlags[0]}, {16'd0, 16'd1});

    // R7 mode off sets nothing
    wcfg(2'd0, 32'd1);
    wcfg(2'd2, ctl(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 5'd0));
    restart(3'b001);
    ticks(2);
    chk("R7 mode off", {count0, 13'd0, irqFlags, irqOut, rstReq}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule